// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave on a Two-Wire Bus

This block is a target on a two-wire SMBus-style bus. It gives a host block access to a bank of 8-bit configuration registers, with the starting position chosen by index. SCL and SDA are sampled with the system clock. SDA is driven through an open-drain enable: while that output is high the line is pulled low. Every register bit is one of two kinds. A writable bit is a flop with its own reset value. A status bit always shows the matching bit of a parallel status input. All register values are presented together on a wide parallel output.

To write, the host sends the write address, a starting index, a byte count and then the data bytes, which land in consecutive registers. To read, the host sends the write address and an index, then a repeated start and the read address. The block answers with a count byte taken from a dedicated count register, followed by register bytes from the index upward. It keeps sending until the host NACKs.

Top module: `smbreg_slave`

## Requirements
- R1: The 8-bit address byte 0xD2 (write) and 0xD3 (read) is ACKed. Any other address byte is NACKed, and every byte after it is NACKed and has no effect until the next start or stop.
- R2: In a write transfer the slave ACKs the index byte, the count byte and every data byte, and data byte k is stored into register index+k.
- R3: Data bytes beyond the count sent in the write transfer are ACKed but leave every register unchanged.
- R4: After a repeated start with 0xD3, the slave first sends a count byte whose bits 5:0 equal bits 5:0 of the count register (index 12) and whose bits 7:6 are 0. It then sends registers index, index+1 and so on, MSB first, for as long as the host ACKs. After a NACK it releases SDA.
- R5: Writes to status bits (by default all of register 7 and bits 7:4 of register 8) have no effect. Those bits always read, and appear on the parallel output, as the status input.
- R6: After reset the writable bits hold their defaults. By default register 12 is 0x0D, register 8 bits 3:0 are 0x2, register 4 is 0xDE, registers 2 and 3 are 0xFF, register 1 is 0x0F, and the rest are 0x00.
- R7: A write to the count register whose bits 5:0 exceed 32 stores 32 in bits 5:0. Bits 7:6 are stored as written.
- R8: The register index saturates one past the last register and does not wrap. Writes at or past that point are ACKed and discarded. Reads there return 0x00.
- R9: A stop in any state ends the transfer, and later bytes are not stored. A start in any state, even in the middle of a byte, begins a new address phase.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | High pulls the data line low |
| status_i | input | NUM_REGS*8 | Status values shown in status bits, register r at [8r+7:8r] |
| reg_q_o | output | NUM_REGS*8 | Current value of every register, same layout |

## Verification
The hardest situations to reach are the aborts. One is a start that arrives after only half of a byte has been shifted in. Another is a stop placed right after a data byte, before the transfer has used up its count. The host tasks in the bench work bit by bit, so the stimulus can leave a byte unfinished and insert a repeated start in the middle of it. A complete read must follow each abort and return the correct count byte. The other hard point is the upper end of the register range. Writes that start near the last register and run past it, and reads that begin beyond it, show whether the index saturates and whether the count-register clamp and the status bits hold together.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_COUNT,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } smb_state_e;

  localparam int DEF_NUM_REGS = 13;

  // register 12 first, register 0 last; 1 = writable bit
  localparam logic [DEF_NUM_REGS*8-1:0] DEF_RW_MASK =
    104'hFFFF_FFFF_0F00_FFFF_FFFF_FFFF_FF;
  localparam logic [DEF_NUM_REGS*8-1:0] DEF_RST_VAL =
    104'h0D00_0000_0200_0000_DEFF_FF0F_00;

endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank #(
  parameter int NUM_REGS = 13,
  parameter int IDXW     = 4,
  parameter int CNT_IDX  = 12,
  parameter int CNT_MAX  = 32,
  parameter logic [NUM_REGS*8-1:0] RW_MASK = '1,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [NUM_REGS*8-1:0] status_i,
  output logic [NUM_REGS*8-1:0] view_o
);
  localparam logic [5:0] CAP6 = 6'(CNT_MAX);

  logic [NUM_REGS*8-1:0] q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [7:0] wv;
    logic       sel;
    assign sel = wr_en && (wr_idx == IDXW'(r));
    if (r == CNT_IDX) begin : g_cap
      assign wv = {wr_data[7:6], (wr_data[5:0] > CAP6) ? CAP6 : wr_data[5:0]};
    end else begin : g_pass
      assign wv = wr_data;
    end
    for (genvar b = 0; b < 8; b++) begin : g_bit
      if (RW_MASK[r*8+b]) begin : g_rw
        logic bq;
        always_ff @(posedge clk) begin
          if (rst)      bq <= RST_VAL[r*8+b];
          else if (sel) bq <= wv[b];
        end
        assign q[r*8+b] = bq;
      end else begin : g_ro
        assign q[r*8+b] = 1'b0;
      end
    end
  end

  assign view_o = (q & RW_MASK) | (status_i & ~RW_MASK);
endmodule

// File: rtl/smbreg_proto.sv
module smbreg_proto
  import smbreg_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int IDXW     = 4,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rd_data,
  input  logic [7:0]      cnt_byte,
  output logic [IDXW-1:0] rd_idx,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data
);
  localparam logic [IDXW-1:0] END_IDX = IDXW'(NUM_REGS);
  localparam logic [7:0]      NUM8    = 8'(NUM_REGS);

  smb_state_e      state, nxt;
  logic [3:0]      bitcnt;
  logic [7:0]      sh, tx_sh, wcnt;
  logic [IDXW-1:0] idx;
  logic            acked;

  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      tx_sh   <= '0;
      wcnt    <= '0;
      idx     <= '0;
      acked   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              case (state)
                ST_ADDR: begin
                  if (sh == WR_ADDR) nxt <= ST_INDEX;
                  else if (sh == RD_ADDR) nxt <= ST_TX;
                  else begin
                    state  <= ST_WAIT;
                    sda_oe <= 1'b0;
                  end
                end
                ST_INDEX: begin
                  idx <= (sh >= NUM8) ? END_IDX : sh[IDXW-1:0];
                  nxt <= ST_COUNT;
                end
                ST_COUNT: begin
                  wcnt <= sh;
                  nxt  <= ST_WDATA;
                end
                default: begin
                  nxt <= ST_WDATA;
                  if (wcnt != 8'd0) begin
                    wcnt <= wcnt - 8'd1;
                    if (idx != END_IDX) begin
                      wr_en   <= 1'b1;
                      wr_idx  <= idx;
                      wr_data <= sh;
                      idx     <= idx + IDXW'(1);
                    end
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= nxt;
              bitcnt <= '0;
              if (nxt == ST_TX) begin
                tx_sh  <= cnt_byte;
                sda_oe <= ~cnt_byte[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_TXACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) acked <= ~sda_s;
            else if (scl_fall) begin
              if (acked) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
                state  <= ST_TX;
                if (idx != END_IDX) idx <= idx + IDXW'(1);
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
  import smbreg_pkg::*;
#(
  parameter int NUM_REGS    = DEF_NUM_REGS,
  parameter int CNT_IDX     = 12,
  parameter int CNT_MAX     = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RW_MASK = DEF_RW_MASK,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = DEF_RST_VAL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [NUM_REGS*8-1:0] status_i,
  output logic [NUM_REGS*8-1:0] reg_q_o
);
  localparam int IDXW  = $clog2(NUM_REGS + 1);
  localparam int SLOTS = 1 << IDXW;

  logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_data, rd_data, cnt_byte;
  logic [NUM_REGS*8-1:0] view;
  logic [7:0]      slot [SLOTS];

  smbreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbreg_proto #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_proto (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .cnt_byte(cnt_byte), .rd_idx(rd_idx),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  smbreg_bank #(
    .NUM_REGS(NUM_REGS), .IDXW(IDXW), .CNT_IDX(CNT_IDX), .CNT_MAX(CNT_MAX),
    .RW_MASK(RW_MASK), .RST_VAL(RST_VAL)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .status_i(status_i), .view_o(view)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_REGS) begin : g_live
      assign slot[i] = view[i*8 +: 8];
    end else begin : g_blank
      assign slot[i] = 8'h00;
    end
  end

  assign rd_data  = slot[rd_idx];
  assign cnt_byte = {2'b00, view[CNT_IDX*8 +: 6]};
  assign reg_q_o  = view;
endmodule

// File: rtl/smbreg_chk.sv
module smbreg_chk #(
  parameter int NUM_REGS = 13,
  parameter int IDXW     = 4,
  parameter int CNT_IDX  = 12,
  parameter int CNT_MAX  = 32,
  parameter logic [NUM_REGS*8-1:0] RW_MASK = '1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_s,
  input logic                  stop_det,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [IDXW-1:0]       wr_idx,
  input logic [NUM_REGS*8-1:0] status_i,
  input logic [NUM_REGS*8-1:0] reg_q_o
);
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_count_cap_R7: assert property (@(posedge clk) disable iff (rst)
    reg_q_o[CNT_IDX*8 +: 6] <= 6'(CNT_MAX));

  assert_write_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IDXW'(NUM_REGS)));

  assert_status_bits_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((reg_q_o & ~RW_MASK) == (status_i & ~RW_MASK)));
endmodule

bind smbreg_slave smbreg_chk #(
  .NUM_REGS(NUM_REGS), .IDXW(IDXW), .CNT_IDX(CNT_IDX), .CNT_MAX(CNT_MAX),
  .RW_MASK(RW_MASK)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
  .status_i(status_i), .reg_q_o(reg_q_o)
);

// File: tb/smbreg_slave_tb.sv
module smbreg_slave_tb;
  localparam int N = 13;
  localparam int W = N * 8;
  localparam logic [W-1:0] MASK = 104'hFFFF_FFFF_0F00_FFFF_FFFF_FFFF_FF;
  localparam logic [W-1:0] DEF  = 104'h0D00_0000_0200_0000_DEFF_FF0F_00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [W-1:0] status, reg_q;
  wire  sda_line = sda_h & ~sda_oe;

  smbreg_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .status_i(status), .reg_q_o(reg_q)
  );

  int checks = 0, fails = 0, r10_viol = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] mrw [N];
  logic prev_oe = 1'b0;

  function automatic logic [7:0] mview(int i);
    if (i >= N) return 8'h00;
    return (mrw[i] & MASK[i*8 +: 8]) | (status[i*8 +: 8] & ~MASK[i*8 +: 8]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock while no byte is in flight
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      for (int i = 0; i < N; i++) begin
        if (reg_q[i*8 +: 8] !== mview(i)) begin
          fails++;
          $display("FAIL R2/R5 model reg%0d actual=%0h expected=%0h",
                   i, reg_q[i*8 +: 8], mview(i));
        end
      end
    end
    if (!rst && sda_oe !== prev_oe && scl_h) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic hw(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tx_bit(logic b);
    sda_h = b; hw(4); scl_h = 1'b1; hw(8); scl_h = 1'b0; hw(6);
  endtask

  task automatic rx_bit(output logic b);
    sda_h = 1'b1; hw(4); scl_h = 1'b1; hw(4); b = sda_line; hw(4);
    scl_h = 1'b0; hw(6);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; hw(6); sda_h = 1'b0; hw(8); scl_h = 1'b0; hw(6);
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; hw(4); scl_h = 1'b1; hw(8); sda_h = 1'b0; hw(8);
    scl_h = 1'b0; hw(6);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hw(4); scl_h = 1'b1; hw(8); sda_h = 1'b1; hw(8);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    rx_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(logic host_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rx_bit(x);
      b[i] = x;
    end
    tx_bit(~host_ack);
    sda_h = 1'b1;
  endtask

  function automatic void model_write(int i, logic [7:0] v);
    logic [7:0] w;
    if (i >= N) return;
    w = v;
    if (i == 12 && w[5:0] > 6'd32) w[5:0] = 6'd32;
    mrw[i] = w;
  endfunction

  task automatic blk_write(string tag, int idx, int cnt, logic [7:0] d[$]);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk({tag, " addr ack"}, 32'(a), 1);
    send_byte(8'(idx), a); chk({tag, " index ack"}, 32'(a), 1);
    send_byte(8'(cnt), a); chk({tag, " count ack"}, 32'(a), 1);
    for (int k = 0; k < d.size(); k++) begin
      cmp_en = 1'b0;
      send_byte(d[k], a);
      chk({tag, " data ack"}, 32'(a), 1);
      if (k < cnt && idx < N) model_write(idx + k, d[k]);
      hw(2);
      cmp_en = 1'b1;
    end
    bus_stop();
  endtask

  task automatic blk_read(string tag, int idx, int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a); chk({tag, " addr ack"}, 32'(a), 1);
    send_byte(8'(idx), a); chk({tag, " index ack"}, 32'(a), 1);
    bus_rstart();
    send_byte(8'hD3, a); chk({tag, " read addr ack R1"}, 32'(a), 1);
    recv_byte(1'b1, b);
    chk({tag, " count byte R4"}, 32'(b), 32'({2'b00, mview(12)[5:0]}));
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk({tag, " data byte"}, 32'(b), 32'(mview(idx + k)));
    end
    hw(4);
    chk({tag, " release after NACK R4"}, 32'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    status = {N{8'hA5}};
    status[7*8 +: 8] = 8'h21;
    status[8*8 +: 8] = 8'h6C;
    for (int i = 0; i < N; i++) mrw[i] = DEF[i*8 +: 8];
    hw(10);
    rst = 1'b0;
    hw(4);

    // R6: defaults after reset
    for (int i = 0; i < N; i++) chk("R6 reset value", 32'(reg_q[i*8 +: 8]), 32'(mview(i)));
    chk("R6 count reg", 32'(reg_q[12*8 +: 8]), 32'h0D);
    chk("R6 sda released", 32'(sda_oe), 0);
    cmp_en = 1'b1;

    // R2: plain write, R4: read back
    blk_write("R2 write", 0, 3, '{8'h11, 8'h22, 8'h33});
    blk_read("R4 read", 0, 4);

    // R3: bytes past count discarded
    blk_write("R3 overrun", 4, 2, '{8'h44, 8'h55, 8'h66, 8'h77});
    chk("R3 reg6 untouched", 32'(reg_q[6*8 +: 8]), 32'h00);

    // R5: status bits ignore writes and follow status input
    blk_write("R5 ro write", 7, 2, '{8'hFF, 8'hFF});
    chk("R5 reg7 status", 32'(reg_q[7*8 +: 8]), 32'h21);
    chk("R5 reg8 mixed", 32'(reg_q[8*8 +: 8]), 32'h6F);
    status[7*8 +: 8] = 8'h31;
    hw(2);
    blk_read("R5 read", 7, 2);

    // R7: count field clamp
    blk_write("R7 clamp", 12, 1, '{8'h28});
    chk("R7 count clamped", 32'(reg_q[12*8 +: 8]), 32'h20);
    blk_read("R7 read", 12, 1);

    // R8: running off the end, reads past end
    blk_write("R8 tail", 11, 4, '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
    chk("R8 reg11", 32'(reg_q[11*8 +: 8]), 32'hA1);
    chk("R8 reg12 clamp", 32'(reg_q[12*8 +: 8]), 32'hA0);
    blk_read("R8 read tail", 11, 4);
    blk_write("R8 far index", 200, 2, '{8'h99, 8'h98});
    blk_read("R8 read far", 200, 2);
    blk_write("R7 small count", 12, 1, '{8'hC5});
    blk_read("R7 count 5", 10, 3);

    // R1: foreign address ignored
    cmp_en = 1'b1;
    bus_start();
    send_byte(8'hA4, a); chk("R1 foreign addr nack", 32'(a), 0);
    send_byte(8'h00, a); chk("R1 later byte nack", 32'(a), 0);
    send_byte(8'h01, a); chk("R1 later byte nack", 32'(a), 0);
    send_byte(8'h77, a); chk("R1 later byte nack", 32'(a), 0);
    bus_stop();
    chk("R1 reg0 kept", 32'(reg_q[0*8 +: 8]), 32'h11);

    // R9: stop mid-transfer
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, a); chk("R9 addr ack", 32'(a), 1);
    send_byte(8'h03, a); chk("R9 index ack", 32'(a), 1);
    send_byte(8'h03, a); chk("R9 count ack", 32'(a), 1);
    send_byte(8'h5A, a); chk("R9 data ack", 32'(a), 1);
    model_write(3, 8'h5A);
    bus_stop();
    hw(2);
    cmp_en = 1'b1;
    bus_start();
    send_byte(8'h66, a); chk("R9 fresh addr nack", 32'(a), 0);
    bus_stop();
    chk("R9 reg3 stored", 32'(reg_q[3*8 +: 8]), 32'h5A);
    chk("R9 reg4 kept", 32'(reg_q[4*8 +: 8]), 32'h44);

    // R9: start in the middle of a byte
    bus_start();
    tx_bit(1'b1); tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bus_rstart();
    send_byte(8'hD2, a); chk("R9 restart addr ack", 32'(a), 1);
    send_byte(8'h02, a); chk("R9 restart index ack", 32'(a), 1);
    bus_rstart();
    send_byte(8'hD3, a); chk("R9 restart read ack", 32'(a), 1);
    recv_byte(1'b1, b); chk("R9 restart count R4", 32'(b), 32'h05);
    recv_byte(1'b0, b); chk("R9 restart data", 32'(b), 32'(mview(2)));
    bus_stop();

    hw(10);
    chk("R10 drive changes only with SCL low", 32'(r10_viol), 0);
    done = 1'b1;
    finish_run();
  end
endmodule